// File: doc/BRIEF.md
# Delayed Single-Word Write Forwarder

This block carries non-posted, single-DWORD writes from an initiator-side bus to a target-side bus. The initiator side sees I/O writes and type 1 configuration writes. The first time such a write arrives, the block claims it and answers with retry. It also stores the command, address, address parity, data DWORD, byte enables and data parity in a small in-order queue. Any other command passes through unclaimed.

On the target side, the block replays the oldest stored write. It does so only when an external ordering-permission input allows it. If the target answers with retry, the write is reissued. A programmable limit on consecutive retries turns an endless retry into a system error. A target abort or a master abort ends the retrying with an error status.

When the initiator repeats the write and it matches the completed oldest entry, the block answers with completion. It answers with target abort instead if the delivery failed. The entry then leaves the queue. Only enabled bytes take part in the data comparison.

Each request is one beat that carries both the address-phase and the data-phase fields. The initiator side accepts one beat per cycle while `in_ready` is high, and `in_ready` stays high after reset. Every accepted beat produces exactly one response cycle on the following clock. On the target side the block presents one write attempt with `out_valid`. The attempt's fields stay stable until `out_ready` accepts it. The environment then returns exactly one `tgt_rsp_valid` pulse with the outcome.

Top module: `dwc_ctrl`

## Requirements
- R1: A beat is a delayed write only if its command is 4'b0011 (I/O write), or its command is 4'b1011 (configuration write) with address bits [1:0] equal to 2'b01 (type 1). Any other beat gets a response cycle with `rsp_devsel`, `rsp_trdy` and `rsp_stop` all low, and nothing is queued.
- R2: A delayed write that matches no queued entry by command and address, arriving while the queue has room, is answered one cycle after acceptance with `rsp_devsel`=1, `rsp_stop`=1 and `rsp_trdy`=0 (retry). It is appended to the queue.
- R3: A delayed write whose command and address equal those of a queued entry, or one that arrives with all DEPTH entries in use, is answered with retry and not appended.
- R4: The oldest entry is presented on `out_*` only if it has not completed and `order_ok` was high in the cycle before `out_valid` rises. The presented fields equal the fields captured at the initiator side.
- R5: Code 2'd0 on `tgt_rsp` completes the entry. Code 2'd1 (retry) makes the block present the same entry again.
- R6: After 2^LIM_DEF_LOG2 consecutive retries (2^LIM_MAX_LOG2 when `lim_max`=1), the entry completes with error and `sys_err` pulses for one cycle. `serr_o` pulses with it only when `serr_en` is set.
- R7: A delayed write that matches the completed, error-free oldest entry is answered with `rsp_devsel`=1 and `rsp_trdy`=1, with `rsp_stop`=1 only when `in_multi` is set. The entry is removed.
- R8: The match in R7 requires equal command, address and byte enables. It compares only data bytes whose active-low enable bit is 0, and a byte with enable bit 1 may differ.
- R9: Code 2'd2 (target abort) or 2'd3 (master abort) ends delivery with error. The matching repeat is answered with `rsp_stop`=1, `rsp_devsel`=0 and `rsp_trdy`=0, and the entry is removed. An entry that completed through R6 is answered the same way.
- R10: Entries are presented on the target side in the order they were queued.
- R11: `in_ready` is high in every cycle after reset. While `out_valid` is high and `out_ready` low, `out_valid` and the `out_*` fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Initiator beat present |
| in_ready | output | 1 | Initiator beat accepted |
| in_cmd | input | 4 | Bus command |
| in_addr | input | 32 | Address |
| in_apar | input | 1 | Address parity |
| in_data | input | 32 | First data DWORD |
| in_be_n | input | 4 | Byte enables, active low |
| in_dpar | input | 1 | Data parity |
| in_multi | input | 1 | Initiator wants more than one DWORD |
| rsp_valid | output | 1 | Response cycle for the previous beat |
| rsp_devsel | output | 1 | Access claimed |
| rsp_trdy | output | 1 | Data transferred |
| rsp_stop | output | 1 | Stop request (retry, disconnect or abort) |
| order_ok | input | 1 | Ordering rules permit issuing the head entry |
| out_valid | output | 1 | Write attempt presented |
| out_ready | input | 1 | Write attempt taken |
| out_cmd | output | 4 | Replayed command |
| out_addr | output | 32 | Replayed address |
| out_apar | output | 1 | Replayed address parity |
| out_data | output | 32 | Replayed data |
| out_be_n | output | 4 | Replayed byte enables |
| out_dpar | output | 1 | Replayed data parity |
| tgt_rsp_valid | input | 1 | Target outcome present |
| tgt_rsp | input | 2 | Outcome: 0 done, 1 retry, 2 target abort, 3 master abort |
| lim_max | input | 1 | Select the larger retry limit |
| serr_en | input | 1 | Permit the system-error output |
| sys_err | output | 1 | Retry limit reached (one-cycle pulse) |
| serr_o | output | 1 | Gated system-error pulse |

## Verification
The assertions rely on the target side returning exactly one `tgt_rsp_valid` pulse per accepted attempt, and never one while no attempt is outstanding. They also rely on `lim_max` changing only while no retry count is building up. The bench's target model enforces both: it waits for an `out_valid`/`out_ready` handshake and then answers once, after a random delay. Its outcome is a fixed function of the address and the retry count so far. Initiator beats, `order_ok` and `serr_en` change only at the falling edge. `lim_max` is switched only while the queue is empty.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int CMD_W  = 4;

  localparam logic [CMD_W-1:0] CMD_IO_WR  = 4'b0011;
  localparam logic [CMD_W-1:0] CMD_CFG_WR = 4'b1011;

  typedef enum logic [1:0] {
    TR_DONE   = 2'd0,
    TR_RETRY  = 2'd1,
    TR_TABORT = 2'd2,
    TR_MABORT = 2'd3
  } tgt_code_t;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic              apar;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be_n;
    logic              dpar;
  } dwc_entry_t;

  // delayed path: I/O write, or configuration write of type 1
  function automatic logic is_delayed_wr(input logic [CMD_W-1:0] cmd,
                                         input logic [1:0] addr_lo);
    return (cmd == CMD_IO_WR) || ((cmd == CMD_CFG_WR) && (addr_lo == 2'b01));
  endfunction

  // compare only the bytes whose active-low enable is asserted
  function automatic logic masked_eq(input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b,
                                     input logic [BE_W-1:0]   be_n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < BE_W; i++)
      if (!be_n[i] && (a[8*i +: 8] != b[8*i +: 8])) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/dwc_queue.sv
module dwc_queue
  import dwc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  dwc_entry_t        push_e,
  input  logic              pop,
  input  logic              mark_done,
  input  logic              mark_err,
  input  logic [CMD_W-1:0]  key_cmd,
  input  logic [ADDR_W-1:0] key_addr,
  output logic              key_hit,
  output logic              full,
  output logic              empty,
  output dwc_entry_t        head_e,
  output logic              head_done,
  output logic              head_err
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

  dwc_entry_t       mem [DEPTH];
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [PW:0]      cnt;
  logic [DEPTH-1:0] slot_hit;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (cnt == FULL_CNT);
  assign empty   = (cnt == '0);
  assign head_e  = mem[rd_ptr];
  assign key_hit = |slot_hit;

  // per-slot liveness and address/command lookup
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [PW:0] off;
    assign off = (PW'(i) >= rd_ptr) ? ({1'b0, PW'(i)} - {1'b0, rd_ptr})
                                    : ((PW+1)'(i + DEPTH) - {1'b0, rd_ptr});
    assign slot_hit[i] = (off < cnt) && (mem[i].cmd == key_cmd) &&
                         (mem[i].addr == key_addr);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_e;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      cnt       <= '0;
      head_done <= 1'b0;
      head_err  <= 1'b0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop) begin
        rd_ptr    <= bump(rd_ptr);
        head_done <= 1'b0;
        head_err  <= 1'b0;
      end else if (mark_done) begin
        head_done <= 1'b1;
        head_err  <= mark_err;
      end
      case ({push, pop})
        2'b10:   cnt <= cnt + (PW+1)'(1);
        2'b01:   cnt <= cnt - (PW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dwc_init_side.sv
module dwc_init_side
  import dwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CMD_W-1:0]  in_cmd,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_apar,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be_n,
  input  logic              in_dpar,
  input  logic              in_multi,
  input  logic              q_full,
  input  logic              q_empty,
  input  logic              q_hit,
  input  logic              q_head_done,
  input  logic              q_head_err,
  input  logic [CMD_W-1:0]  head_cmd,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [DATA_W-1:0] head_data,
  input  logic [BE_W-1:0]   head_be_n,
  output logic              push,
  output dwc_entry_t        push_e,
  output logic              pop,
  output logic              rsp_valid,
  output logic              rsp_devsel,
  output logic              rsp_trdy,
  output logic              rsp_stop
);
  logic acc, qual, head_match;

  assign acc  = in_valid && in_ready;
  assign qual = is_delayed_wr(in_cmd, in_addr[1:0]);

  assign head_match = !q_empty && q_head_done &&
                      (head_cmd == in_cmd) && (head_addr == in_addr) &&
                      (head_be_n == in_be_n) &&
                      masked_eq(head_data, in_data, in_be_n);

  assign pop  = acc && qual && head_match;
  assign push = acc && qual && !head_match && !q_hit && !q_full;

  always_comb begin
    push_e      = '0;
    push_e.cmd  = in_cmd;
    push_e.addr = in_addr;
    push_e.apar = in_apar;
    push_e.data = in_data;
    push_e.be_n = in_be_n;
    push_e.dpar = in_dpar;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready   <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_devsel <= 1'b0;
      rsp_trdy   <= 1'b0;
      rsp_stop   <= 1'b0;
    end else begin
      in_ready   <= 1'b1;
      rsp_valid  <= acc;
      rsp_devsel <= acc && qual && !(head_match && q_head_err);
      rsp_trdy   <= acc && qual && head_match && !q_head_err;
      rsp_stop   <= acc && qual && (!head_match || q_head_err || in_multi);
    end
  end
endmodule

// File: rtl/dwc_tgt_side.sv
module dwc_tgt_side
  import dwc_pkg::*;
#(
  parameter int LIM_DEF_LOG2 = 24,
  parameter int LIM_MAX_LOG2 = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       q_empty,
  input  logic       q_head_done,
  input  dwc_entry_t head_e,
  input  logic       order_ok,
  output logic       out_valid,
  input  logic       out_ready,
  output dwc_entry_t out_e,
  input  logic       tgt_rsp_valid,
  input  logic [1:0] tgt_rsp,
  input  logic       lim_max,
  input  logic       serr_en,
  output logic       mark_done,
  output logic       mark_err,
  output logic       sys_err,
  output logic       serr_o
);
  localparam int CW = LIM_MAX_LOG2 + 1;

  typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT} tstate_t;

  tstate_t   state;
  logic [CW-1:0] tries, lim, tries_nxt;
  tgt_code_t code;
  logic      exhaust;

  assign lim       = lim_max ? (CW'(1) << LIM_MAX_LOG2) : (CW'(1) << LIM_DEF_LOG2);
  assign tries_nxt = tries + CW'(1);
  assign code      = tgt_code_t'(tgt_rsp);
  assign out_valid = (state == T_ISSUE);
  assign out_e     = head_e;

  always_comb begin
    mark_done = 1'b0;
    mark_err  = 1'b0;
    exhaust   = 1'b0;
    if (state == T_WAIT && tgt_rsp_valid) begin
      case (code)
        TR_DONE:  mark_done = 1'b1;
        TR_RETRY: begin
          exhaust   = (tries_nxt == lim);
          mark_done = exhaust;
          mark_err  = exhaust;
        end
        default: begin
          mark_done = 1'b1;
          mark_err  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= T_IDLE;
      tries   <= '0;
      sys_err <= 1'b0;
      serr_o  <= 1'b0;
    end else begin
      sys_err <= exhaust;
      serr_o  <= exhaust && serr_en;
      case (state)
        T_IDLE:  if (!q_empty && !q_head_done && order_ok) state <= T_ISSUE;
        T_ISSUE: if (out_ready) state <= T_WAIT;
        default: if (tgt_rsp_valid) begin
          state <= T_IDLE;
          tries <= (code == TR_RETRY && !exhaust) ? tries_nxt : '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dwc_ctrl.sv
module dwc_ctrl
  import dwc_pkg::*;
#(
  parameter int DEPTH        = 4,
  parameter int LIM_DEF_LOG2 = 24,
  parameter int LIM_MAX_LOG2 = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [3:0]  in_cmd,
  input  logic [31:0] in_addr,
  input  logic        in_apar,
  input  logic [31:0] in_data,
  input  logic [3:0]  in_be_n,
  input  logic        in_dpar,
  input  logic        in_multi,
  output logic        rsp_valid,
  output logic        rsp_devsel,
  output logic        rsp_trdy,
  output logic        rsp_stop,
  input  logic        order_ok,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [3:0]  out_cmd,
  output logic [31:0] out_addr,
  output logic        out_apar,
  output logic [31:0] out_data,
  output logic [3:0]  out_be_n,
  output logic        out_dpar,
  input  logic        tgt_rsp_valid,
  input  logic [1:0]  tgt_rsp,
  input  logic        lim_max,
  input  logic        serr_en,
  output logic        sys_err,
  output logic        serr_o
);
  logic       q_push, q_pop, q_hit, q_full, q_empty, q_head_done, q_head_err;
  logic       q_mark_done, q_mark_err;
  dwc_entry_t q_push_e, q_head_e, t_out_e;

  dwc_queue #(.DEPTH(DEPTH)) queue_i (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_e(q_push_e), .pop(q_pop),
    .mark_done(q_mark_done), .mark_err(q_mark_err),
    .key_cmd(in_cmd), .key_addr(in_addr), .key_hit(q_hit),
    .full(q_full), .empty(q_empty), .head_e(q_head_e),
    .head_done(q_head_done), .head_err(q_head_err)
  );

  dwc_init_side init_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cmd(in_cmd), .in_addr(in_addr), .in_apar(in_apar), .in_data(in_data),
    .in_be_n(in_be_n), .in_dpar(in_dpar), .in_multi(in_multi),
    .q_full(q_full), .q_empty(q_empty), .q_hit(q_hit),
    .q_head_done(q_head_done), .q_head_err(q_head_err),
    .head_cmd(q_head_e.cmd), .head_addr(q_head_e.addr),
    .head_data(q_head_e.data), .head_be_n(q_head_e.be_n),
    .push(q_push), .push_e(q_push_e), .pop(q_pop),
    .rsp_valid(rsp_valid), .rsp_devsel(rsp_devsel), .rsp_trdy(rsp_trdy),
    .rsp_stop(rsp_stop)
  );

  dwc_tgt_side #(.LIM_DEF_LOG2(LIM_DEF_LOG2), .LIM_MAX_LOG2(LIM_MAX_LOG2)) tgt_i (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_head_done(q_head_done),
    .head_e(q_head_e), .order_ok(order_ok), .out_valid(out_valid),
    .out_ready(out_ready), .out_e(t_out_e), .tgt_rsp_valid(tgt_rsp_valid),
    .tgt_rsp(tgt_rsp), .lim_max(lim_max), .serr_en(serr_en),
    .mark_done(q_mark_done), .mark_err(q_mark_err),
    .sys_err(sys_err), .serr_o(serr_o)
  );

  assign out_cmd  = t_out_e.cmd;
  assign out_addr = t_out_e.addr;
  assign out_apar = t_out_e.apar;
  assign out_data = t_out_e.data;
  assign out_be_n = t_out_e.be_n;
  assign out_dpar = t_out_e.dpar;
endmodule

// File: rtl/dwc_ctrl_chk.sv
module dwc_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        rsp_valid,
  input logic        rsp_devsel,
  input logic        rsp_trdy,
  input logic        order_ok,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_addr,
  input logic [31:0] out_data,
  input logic        serr_en,
  input logic        sys_err,
  input logic        serr_o,
  input logic        q_push,
  input logic        q_pop,
  input logic        q_full,
  input logic        q_head_done
);
  assert_rsp_after_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(in_valid && in_ready));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> !q_full);

  assert_issue_permitted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(order_ok));

  assert_no_replay_of_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !q_head_done);

  assert_serr_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> (sys_err && $past(serr_en)));

  assert_trdy_claimed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trdy |-> rsp_devsel);

  assert_pop_only_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> q_head_done);

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));
endmodule

bind dwc_ctrl dwc_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .rsp_valid(rsp_valid), .rsp_devsel(rsp_devsel), .rsp_trdy(rsp_trdy),
  .order_ok(order_ok), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_data(out_data), .serr_en(serr_en),
  .sys_err(sys_err), .serr_o(serr_o), .q_push(q_push), .q_pop(q_pop),
  .q_full(q_full), .q_head_done(q_head_done)
);

// File: tb/dwc_ctrl_tb_top.sv
`timescale 1ns/1ps
module dwc_ctrl_tb_top;
  localparam int DEPTH = 4;
  localparam int LD = 2;
  localparam int LM = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_apar, in_dpar, in_multi;
  logic [3:0] in_cmd, in_be_n, out_cmd, out_be_n;
  logic [31:0] in_addr, in_data, out_addr, out_data;
  logic rsp_valid, rsp_devsel, rsp_trdy, rsp_stop, order_ok;
  logic out_valid, out_ready, out_apar, out_dpar, tgt_rsp_valid;
  logic [1:0] tgt_rsp;
  logic lim_max, serr_en, sys_err, serr_o;

  dwc_ctrl #(.DEPTH(DEPTH), .LIM_DEF_LOG2(LD), .LIM_MAX_LOG2(LM)) dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit tgt_rand = 0;

  // bench model of the queue
  logic [3:0]  m_cmd [DEPTH];
  logic [31:0] m_addr[DEPTH], m_data[DEPTH];
  logic [3:0]  m_be  [DEPTH];
  logic        m_ap  [DEPTH], m_dp[DEPTH];
  int m_rd = 0, m_wr = 0, m_cnt = 0, m_att = 0;
  bit m_done = 0, m_err = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic bit b_qual(input logic [3:0] c, input logic [31:0] a);
    return (c == 4'b0011) || (c == 4'b1011 && a[1:0] == 2'b01);
  endfunction

  function automatic bit b_same(input logic [31:0] x, input logic [31:0] y,
                                input logic [3:0] be);
    for (int k = 0; k < 4; k++)
      if (be[k] == 1'b0 && x[8*k +: 8] != y[8*k +: 8]) return 0;
    return 1;
  endfunction

  function automatic bit b_hit(input logic [3:0] c, input logic [31:0] a);
    for (int k = 0; k < m_cnt; k++) begin
      int ix = (m_rd + k) % DEPTH;
      if (m_cmd[ix] == c && m_addr[ix] == a) return 1;
    end
    return 0;
  endfunction

  // target outcome: a[9] retries forever, a[5:4] retries first, a[8:7] picks abort kind
  function automatic logic [1:0] pol(input logic [31:0] a, input int att);
    if (a[9]) return 2'd1;
    if (att < int'(a[5:4])) return 2'd1;
    case (a[8:7])
      2'd2: return 2'd2;
      2'd3: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic send(input logic [3:0] c, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, input bit multi, input string rq_in);
    bit q, hm, hit, ed, et, es, ap, dp;
    string rq;
    @(negedge clk);
    check(in_ready == 1'b1, "R11", "in_ready", in_ready, 1);
    q   = b_qual(c, a);
    hit = b_hit(c, a);
    hm  = q && m_cnt > 0 && m_done && m_cmd[m_rd] == c && m_addr[m_rd] == a &&
          m_be[m_rd] == be && b_same(m_data[m_rd], d, be);
    if (!q) begin ed = 0; et = 0; es = 0; rq = "R1"; end
    else if (hm) begin
      ed = !m_err; et = !m_err; es = m_err || multi; rq = m_err ? "R9" : "R7";
    end else begin
      ed = 1; et = 0; es = 1; rq = (hit || m_cnt == DEPTH) ? "R3" : "R2";
    end
    if (rq_in != "") rq = rq_in;
    ap = 1'($urandom); dp = 1'($urandom);
    in_valid = 1; in_cmd = c; in_addr = a; in_data = d; in_be_n = be;
    in_multi = multi; in_apar = ap; in_dpar = dp;
    @(posedge clk); #1;
    if (hm) begin
      m_rd = (m_rd + 1) % DEPTH; m_cnt--; m_done = 0; m_err = 0; m_att = 0;
    end else if (q && !hit && m_cnt < DEPTH) begin
      m_cmd[m_wr] = c; m_addr[m_wr] = a; m_data[m_wr] = d; m_be[m_wr] = be;
      m_ap[m_wr] = ap; m_dp[m_wr] = dp; m_wr = (m_wr + 1) % DEPTH; m_cnt++;
    end
    @(negedge clk);
    in_valid = 0;
    check(rsp_valid == 1'b1, rq, "rsp_valid", rsp_valid, 1);
    check({rsp_devsel, rsp_trdy, rsp_stop} == {ed, et, es}, rq, "devsel/trdy/stop",
          {rsp_devsel, rsp_trdy, rsp_stop}, {ed, et, es});
  endtask

  task automatic wait_head_done();
    for (int k = 0; k < 400 && !(m_cnt > 0 && m_done); k++) @(negedge clk);
  endtask

  task automatic collect(input bit multi, input string rq);
    send(m_cmd[m_rd], m_addr[m_rd], m_data[m_rd], m_be[m_rd], multi, rq);
  endtask

  // target-side responder and checker
  initial begin : tgt_proc
    out_ready = 0; tgt_rsp_valid = 0; tgt_rsp = 0;
    forever begin
      @(negedge clk);
      out_ready = tgt_rand ? ($urandom_range(3) != 0) : 1'b1;
      if (rst_n && out_valid && out_ready) begin
        logic [1:0] code;
        int lim;
        check(m_cnt > 0 && !m_done, "R5", "issue of pending head", m_done, 0);
        check(out_addr == m_addr[m_rd] && out_cmd == m_cmd[m_rd], "R10", "issued addr",
              out_addr, m_addr[m_rd]);
        check(out_data == m_data[m_rd] && out_be_n == m_be[m_rd] &&
              out_apar == m_ap[m_rd] && out_dpar == m_dp[m_rd], "R4", "issued data",
              out_data, m_data[m_rd]);
        code = pol(out_addr, m_att);
        @(posedge clk); #1;
        out_ready = 0;
        @(negedge clk);
        if (tgt_rand) repeat ($urandom_range(2)) @(negedge clk);
        tgt_rsp_valid = 1; tgt_rsp = code;
        @(posedge clk); #1;
        lim = lim_max ? (1 << LM) : (1 << LD);
        if (code == 2'd1) begin
          m_att++;
          if (m_att == lim) begin
            m_done = 1; m_err = 1; m_att = 0;
            check(sys_err == 1'b1, "R6", "sys_err on limit", sys_err, 1);
            check(serr_o == serr_en, "R6", "serr_o gating", serr_o, serr_en);
          end else check(sys_err == 1'b0, "R6", "sys_err early", sys_err, 0);
        end else begin
          m_done = 1; m_err = (code != 2'd0); m_att = 0;
          check(sys_err == 1'b0, "R5", "sys_err on end", sys_err, 0);
        end
        @(negedge clk);
        tgt_rsp_valid = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 0; in_valid = 0; in_cmd = 0; in_addr = 0; in_data = 0; in_be_n = 0;
    in_apar = 0; in_dpar = 0; in_multi = 0; order_ok = 1; lim_max = 0; serr_en = 1;
    repeat (4) @(negedge clk);
    check(rsp_valid == 0 && out_valid == 0, "R11", "reset outputs",
          {rsp_valid, out_valid}, 0);
    check(sys_err == 0 && serr_o == 0, "R6", "reset error outputs", {sys_err, serr_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1: memory write and type 0 configuration write are not claimed
    send(4'b0111, 32'h0000_1000, 32'hA5A5_0001, 4'h0, 0, "R1");
    send(4'b1011, 32'h0000_1000, 32'hA5A5_0002, 4'h0, 0, "R1");
    check(m_cnt == 0 && out_valid == 0, "R1", "nothing queued", out_valid, 0);

    // R4: ordering permission withheld
    order_ok = 0;
    send(4'b0011, 32'h0000_1000, 32'h1122_3344, 4'b0100, 0, "R2");
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(out_valid == 0, "R4", "held by order_ok", out_valid, 0);
    end
    order_ok = 1;
    wait_head_done();
    // R8: enabled byte differs -> retry; disabled byte differs -> complete
    send(4'b0011, 32'h0000_1000, 32'h1122_3345, 4'b0100, 0, "R8");
    send(4'b0011, 32'h0000_1000, 32'h11FF_3344, 4'b0100, 1, "R8");
    check(m_cnt == 0, "R7", "entry popped", m_cnt, 0);

    // R3/R10: fill the queue, one extra beat dropped, in-order delivery
    order_ok = 0;
    for (int k = 0; k < DEPTH; k++)
      send(4'b1011, 32'h0000_2001 + 32'(k << 2), 32'h5000_0000 + 32'(k), 4'h0, 0, "R2");
    send(4'b0011, 32'h0000_3000, 32'h6000_0000, 4'h0, 0, "R3");
    order_ok = 1;
    for (int k = 0; k < DEPTH; k++) begin
      wait_head_done();
      collect(0, "R7");
    end
    send(4'b0011, 32'h0000_3000, 32'h6000_0000, 4'h0, 0, "R2");
    wait_head_done();
    collect(0, "R7");

    // R6/R9: retry exhaustion with both limits and both enable settings
    send(4'b0011, 32'h0000_1200, 32'h7, 4'h0, 0, "R2");
    wait_head_done();
    collect(0, "R9");
    lim_max = 1; serr_en = 0;
    send(4'b0011, 32'h0000_1204, 32'h8, 4'h0, 0, "R2");
    wait_head_done();
    collect(1, "R9");
    lim_max = 0; serr_en = 1;
    // R9: master abort and target abort after retries
    send(4'b0011, 32'h0000_1180, 32'h9, 4'h0, 0, "R2");
    wait_head_done();
    collect(0, "R9");
    send(4'b0011, 32'h0000_1130, 32'hA, 4'h0, 0, "R2");
    wait_head_done();
    collect(0, "R9");

    // random traffic
    tgt_rand = 1;
    for (int it = 0; it < 400; it++) begin
      int pick = $urandom_range(99);
      order_ok = ($urandom_range(3) != 0);
      serr_en  = 1'($urandom);
      if (pick < 35 && m_cnt > 0) collect(1'($urandom), "");
      else if (pick < 45) send(4'b0110, 32'($urandom), 32'($urandom), 4'($urandom), 0, "");
      else begin
        bit cfg = 1'($urandom);
        logic [31:0] a;
        a = 32'h0001_0000 | {22'd0, ($urandom_range(15) == 0), ($urandom_range(5) == 0),
                             1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
                             cfg ? 2'b01 : 2'($urandom)};
        send(cfg ? 4'b1011 : 4'b0011, a, 32'($urandom), 4'($urandom),
             1'($urandom), "");
      end
    end
    order_ok = 1;
    for (int k = 0; k < 3 * DEPTH && m_cnt > 0; k++) begin
      wait_head_done();
      collect(0, "");
    end
    check(m_cnt == 0, "R10", "drained", m_cnt, 0);
    summary();
    $finish;
  end
endmodule